// File: doc/BRIEF.md
# MDIO Management Target

This block is the responding end of a two-wire serial management link. It sits next to a PHY's register file. It watches the management clock and data line, finds the start of each frame and decodes the opcode and both address fields. It acts only on frames sent to its own fixed station address. A write frame delivers a register number, a 16-bit value and a single-cycle write strobe to an external register port. A read frame fetches the addressed register through the same port and shifts the value back onto the data line, using an output-enable for the tri-state driver.

The management clock is slow and has no fixed phase relation to the system clock. Both wires are first synchronized into the system clock domain. The rising edges of the management clock are detected there, and each data bit is taken on such an edge. The target changes its own output a few system cycles after the rising edge that ends the previous bit. The master then sees the new value well before its next sampling edge.

Top module: `mgmt_target`

## Requirements
- R1: Only frames whose 5-bit station field equals 10h (binary 10000) are acted on. A frame with any other station address gives no write strobe, no read strobe and no drive for its whole remaining length (register field, two turnaround bits and 16 data bits).
- R2: A frame begins with the two bits 0 then 1. Any number of leading 1 bits may come before them, including none.
- R3: The opcode bits 1,0 (first bit first) select a read and 0,1 select a write. The codes 0,0 and 1,1 abandon the frame with no strobe and no drive.
- R4: The station and register fields are 5 bits each, most significant bit first. `reg_addr` carries the register field as received.
- R5: In a read frame the target leaves the line undriven during the first turnaround bit and drives 0 during the second.
- R6: In a read frame, `reg_rd` pulses once, and the value on `reg_rdata` at that moment is driven as the 16 data bits, bit 15 first.
- R7: In a write frame the target never drives the line. The 16 data bits are taken bit 15 first. After the last bit, `reg_we` pulses for exactly one cycle with `reg_addr` and `reg_wdata` valid.
- R8: `mdio_oe` is high only from the second read turnaround bit to the last read data bit. It falls after the edge that ends the last data bit, so the line returns to its pulled-up idle level.
- R9: While `rst_n` is low, and right after it is released, `mdio_oe`, `reg_we` and `reg_rd` are 0. A reset in the middle of a read stops the drive.
- R10: `mdio_o` and `mdio_oe` change only within a few system cycles after a rising management-clock edge, and stay steady until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdc_i | input | 1 | Management clock from the master, asynchronous |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdio_o | output | 1 | Data value to drive when enabled |
| mdio_oe | output | 1 | Output enable of the tri-state pad driver |
| reg_addr | output | 5 | Register number of the current frame |
| reg_wdata | output | 16 | Write value for the register port |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe, marks the cycle when reg_rdata is taken |
| reg_rdata | input | 16 | Register value for reg_addr, from the register file |

## Verification
The bench sends frames with no preamble, which would be lost by a target that insists on at least one leading 1. It sends frames for a foreign station whose payload holds start-like 0-then-1 patterns, which would trigger false writes in a target that went back to hunting too early. It uses the opcodes 00 and 11, which a loose decoder would treat as read or write. It reads back a register whose 5-bit number is not a palindrome, so that a reversed field picks the wrong register. It checks the undriven first turnaround bit, where an early enable would cause line contention. It also resets the block in the middle of a read, which must stop the drive at once.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  typedef enum logic [3:0] {
    ST_HUNT,
    ST_START,
    ST_OPC,
    ST_PHY,
    ST_REG,
    ST_TA_RD,
    ST_TA_WR,
    ST_RDATA,
    ST_WDATA,
    ST_SKIP
  } mgmt_state_e;

  typedef enum logic [1:0] {
    OPK_READ,
    OPK_WRITE,
    OPK_BAD
  } mgmt_opk_e;

  // bits left in a frame after the station field: register field,
  // two turnaround bits, data field
  function automatic int unsigned tail_bits(int unsigned aw, int unsigned dw);
    return aw + 2 + dw;
  endfunction

  // first received opcode bit is op[1]
  function automatic mgmt_opk_e op_kind(logic [1:0] op);
    case (op)
      2'b10:   return OPK_READ;
      2'b01:   return OPK_WRITE;
      default: return OPK_BAD;
    endcase
  endfunction

endpackage

// File: rtl/mgmt_edge_sync.sv
module mgmt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic bit_stb,
  output logic bit_val
);

  logic [STAGES-1:0] mdc_pipe;
  logic [STAGES-1:0] mdio_pipe;
  logic              mdc_prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mdc_pipe  <= '0;
          mdio_pipe <= '1;
        end else begin
          mdc_pipe  <= mdc_i;
          mdio_pipe <= mdio_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mdc_pipe  <= '0;
          mdio_pipe <= '1;
        end else begin
          mdc_pipe  <= {mdc_pipe[STAGES-2:0], mdc_i};
          mdio_pipe <= {mdio_pipe[STAGES-2:0], mdio_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) mdc_prev <= 1'b0;
    else        mdc_prev <= mdc_pipe[STAGES-1];
  end

  // data and clock travel through equal-length chains, so the data bit
  // seen with the edge is the one present when the clock rose
  assign bit_stb = mdc_pipe[STAGES-1] & ~mdc_prev;
  assign bit_val = mdio_pipe[STAGES-1];

  AST_EDGE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb); // R10

endmodule

// File: rtl/mgmt_frame.sv
module mgmt_frame
  import mgmt_pkg::*;
#(
  parameter int              AW       = 5,
  parameter int              DW       = 16,
  parameter logic [AW-1:0]   PHY_ADDR = 5'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_stb,
  input  logic          bit_val,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          rd_load,
  output logic          rd_shift,
  output logic          rd_done,
  output logic          rd_phase
);

  localparam int SKIP_LEN = int'(tail_bits(AW, DW));
  localparam int CW       = $clog2(SKIP_LEN + 1);
  localparam int SW       = (DW > AW) ? DW : AW;

  mgmt_state_e   state;
  logic [CW-1:0] cnt;
  logic [SW-1:0] sh;
  logic [SW-1:0] sh_next;
  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          we_q, load_q, shift_q, done_q;

  assign sh_next = {sh[SW-2:0], bit_val};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_HUNT;
      cnt     <= '0;
      sh      <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      load_q  <= 1'b0;
      shift_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      we_q    <= 1'b0;
      load_q  <= 1'b0;
      shift_q <= 1'b0;
      done_q  <= 1'b0;
      if (bit_stb) begin
        case (state)
          ST_HUNT: begin
            if (!bit_val) state <= ST_START;
          end
          ST_START: begin
            if (bit_val) begin
              state <= ST_OPC;
              cnt   <= '0;
            end
          end
          ST_OPC: begin
            sh <= sh_next;
            if (cnt == CW'(1)) begin
              op_q <= sh_next[1:0];
              cnt  <= '0;
              if (op_kind(sh_next[1:0]) == OPK_BAD) state <= ST_HUNT;
              else                                  state <= ST_PHY;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PHY: begin
            sh <= sh_next;
            if (cnt == CW'(AW - 1)) begin
              cnt <= '0;
              if (sh_next[AW-1:0] == PHY_ADDR) state <= ST_REG;
              else                             state <= ST_SKIP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_REG: begin
            sh <= sh_next;
            if (cnt == CW'(AW - 1)) begin
              cnt    <= '0;
              addr_q <= sh_next[AW-1:0];
              state  <= (op_kind(op_q) == OPK_READ) ? ST_TA_RD : ST_TA_WR;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_TA_RD: begin
            load_q <= 1'b1;
            cnt    <= '0;
            state  <= ST_RDATA;
          end
          ST_RDATA: begin
            if (cnt == CW'(DW)) begin
              done_q <= 1'b1;
              state  <= ST_HUNT;
            end else begin
              shift_q <= 1'b1;
              cnt     <= cnt + 1'b1;
            end
          end
          ST_TA_WR: begin
            if (cnt == CW'(1)) begin
              cnt   <= '0;
              state <= ST_WDATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_WDATA: begin
            sh <= sh_next;
            if (cnt == CW'(DW - 1)) begin
              wdata_q <= sh_next[DW-1:0];
              we_q    <= 1'b1;
              state   <= ST_HUNT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_SKIP: begin
            if (cnt == CW'(SKIP_LEN - 1)) state <= ST_HUNT;
            else                          cnt   <= cnt + 1'b1;
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign reg_we    = we_q;
  assign rd_load   = load_q;
  assign rd_shift  = shift_q;
  assign rd_done   = done_q;
  assign rd_phase  = (state == ST_RDATA);

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R7
  AST_WE_FOLLOWS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(bit_stb)); // R7
  AST_LOAD_FOLLOWS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |-> $past(bit_stb)); // R6
  AST_NO_SKIP_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !(rd_load || reg_we)); // R1

endmodule

// File: rtl/mgmt_rd_drive.sv
module mgmt_rd_drive #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic          done,
  input  logic [DW-1:0] rdata,
  output logic          mdio_o,
  output logic          mdio_oe
);

  logic [DW-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh      <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (load) begin
      // second turnaround bit: start driving, value 0
      sh      <= rdata;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b1;
    end else if (shift) begin
      mdio_o  <= sh[DW-1];
      sh      <= {sh[DW-2:0], 1'b0};
      mdio_oe <= 1'b1;
    end else if (done) begin
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end
  end

  AST_TA_DRIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o); // R5
  AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load, shift, done})); // R8

endmodule

// File: rtl/mgmt_target.sv
module mgmt_target #(
  parameter int            AW          = 5,
  parameter int            DW          = 16,
  parameter int            SYNC_STAGES = 2,
  parameter logic [AW-1:0] PHY_ADDR    = 5'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mdc_i,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          reg_rd,
  input  logic [DW-1:0] reg_rdata
);

  logic bit_stb, bit_val;
  logic rd_load, rd_shift, rd_done, rd_phase;

  mgmt_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .mdc_i   (mdc_i),
    .mdio_i  (mdio_i),
    .bit_stb (bit_stb),
    .bit_val (bit_val)
  );

  mgmt_frame #(.AW(AW), .DW(DW), .PHY_ADDR(PHY_ADDR)) i_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .bit_val   (bit_val),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .rd_load   (rd_load),
    .rd_shift  (rd_shift),
    .rd_done   (rd_done),
    .rd_phase  (rd_phase)
  );

  mgmt_rd_drive #(.DW(DW)) i_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (rd_load),
    .shift   (rd_shift),
    .done    (rd_done),
    .rdata   (reg_rdata),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
  );

  assign reg_rd = rd_load;

  AST_OE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> (rd_phase || $past(rd_phase))); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> $stable(reg_addr)); // R6
  AST_NO_WE_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && mdio_oe)); // R7
  AST_OUT_MOVES_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> $past(bit_stb, 2)); // R10

endmodule

// File: tb/test_mgmt_target.sv
module test_mgmt_target;

  localparam int HALF = 8;
  localparam int NV   = 13;

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] dat;
    logic [5:0]  pre;
    logic [1:0]  kind;   // 0 ignored, 1 write, 2 read
  } vec_t;

  localparam logic [35:0] VT [NV] = '{
    {2'b01, 5'h10, 5'h03, 16'hA5C3, 6'd32, 2'd1},
    {2'b10, 5'h10, 5'h03, 16'h0000, 6'd32, 2'd2},
    {2'b01, 5'h10, 5'h1F, 16'h8001, 6'd0,  2'd1},
    {2'b10, 5'h10, 5'h1F, 16'h0000, 6'd1,  2'd2},
    {2'b01, 5'h01, 5'h03, 16'h1234, 6'd32, 2'd0},
    {2'b10, 5'h10, 5'h03, 16'h0000, 6'd8,  2'd2},
    {2'b01, 5'h10, 5'h16, 16'h6C39, 6'd32, 2'd1},
    {2'b10, 5'h10, 5'h0D, 16'h0000, 6'd32, 2'd2},
    {2'b10, 5'h10, 5'h16, 16'h0000, 6'd32, 2'd2},
    {2'b11, 5'h10, 5'h03, 16'h0000, 6'd32, 2'd0},
    {2'b00, 5'h10, 5'h03, 16'hFFFF, 6'd32, 2'd0},
    {2'b10, 5'h11, 5'h03, 16'h0000, 6'd32, 2'd0},
    {2'b10, 5'h10, 5'h03, 16'h0000, 6'd32, 2'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mdc = 1'b0;
  logic drv = 1'b1;
  logic mdio_o, mdio_oe, reg_we, reg_rd;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  wire         line = mdio_oe ? mdio_o : drv;

  logic [15:0] mem [32];
  logic [15:0] exp_mem [32];
  logic        mem_ready = 1'b0;

  int nchk = 0, nfail = 0;
  int we_cnt = 0, rd_cnt = 0, oe_cnt = 0, late = 0;
  logic [4:0]  last_waddr = '0;
  logic [15:0] last_wdata = '0;

  always #2.5 clk = ~clk;

  mgmt_target i_mgmt_target (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc_i     (mdc),
    .mdio_i    (line),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata)
  );

  // external register file model
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) begin
    if (!mem_ready) begin
      for (int i = 0; i < 32; i++) mem[i] <= 16'h3C00 | 16'(i);
      mem_ready <= 1'b1;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  // monitor, sampled 1 ns after the clock edge
  logic mdc_prev = 1'b0, oe_prev = 1'b0, o_prev = 1'b0;
  int   since = 0;
  always begin
    @(posedge clk);
    #1;
    if (mdc && !mdc_prev) since = 0;
    else                  since = since + 1;
    if (rst_n && ({mdio_oe, mdio_o} != {oe_prev, o_prev}) && since > 6) late++;
    if (reg_we) begin
      we_cnt++;
      last_waddr = reg_addr;
      last_wdata = reg_wdata;
    end
    if (reg_rd)  rd_cnt++;
    if (mdio_oe) oe_cnt++;
    mdc_prev = mdc;
    oe_prev  = mdio_oe;
    o_prev   = mdio_o;
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  // one management bit; samples the line as the master would at its rising edge
  task automatic mbit(input logic b, output logic ln, output logic oe);
    drv = b;
    repeat (HALF) @(negedge clk);
    ln  = line;
    oe  = mdio_oe;
    mdc = 1'b1;
    repeat (HALF) @(negedge clk);
    mdc = 1'b0;
  endtask

  task automatic send_head(input vec_t v);
    logic ln, oe;
    for (int i = 0; i < int'(v.pre); i++) mbit(1'b1, ln, oe);
    mbit(1'b0, ln, oe);
    mbit(1'b1, ln, oe);
    for (int i = 1; i >= 0; i--) mbit(v.op[i], ln, oe);
    for (int i = 4; i >= 0; i--) mbit(v.phy[i], ln, oe);
    for (int i = 4; i >= 0; i--) mbit(v.rg[i], ln, oe);
  endtask

  task automatic do_frame(input vec_t v, output logic [15:0] rd,
                          output logic ta1_oe, output logic ta2_oe,
                          output logic ta2_ln, output logic end_oe);
    logic ln, oe;
    rd = '1;
    send_head(v);
    if (v.op == 2'b10) begin
      mbit(1'b1, ln, ta1_oe);
      mbit(1'b1, ta2_ln, ta2_oe);
      for (int i = 15; i >= 0; i--) begin
        mbit(1'b1, ln, oe);
        rd[i] = ln;
      end
    end else begin
      ta1_oe = 1'b0; ta2_oe = 1'b0; ta2_ln = 1'b1;
      mbit(1'b1, ln, oe);
      mbit(1'b0, ln, oe);
      for (int i = 15; i >= 0; i--) mbit(v.dat[i], ln, oe);
    end
    mbit(1'b1, ln, end_oe);
    mbit(1'b1, ln, oe);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    vec_t        v;
    logic [15:0] rd;
    logic        t1, t2, t2l, eo, ln, oe;
    int          we0, rd0, oe0;

    for (int i = 0; i < 32; i++) exp_mem[i] = 16'h3C00 | 16'(i);
    repeat (6) @(negedge clk);
    chk(mdio_oe == 1'b0 && reg_we == 1'b0 && reg_rd == 1'b0, "R9", "outputs in reset",
        {mdio_oe, reg_we, reg_rd}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mdio_oe == 1'b0 && reg_we == 1'b0 && reg_rd == 1'b0, "R9", "outputs after reset",
        {mdio_oe, reg_we, reg_rd}, 0);

    for (int n = 0; n < NV; n++) begin
      v   = vec_t'(VT[n]);
      we0 = we_cnt; rd0 = rd_cnt; oe0 = oe_cnt;
      do_frame(v, rd, t1, t2, t2l, eo);
      case (v.kind)
        2'd1: begin
          chk(we_cnt - we0 == 1, (v.pre == 0) ? "R2" : "R7", "write strobes", we_cnt - we0, 1);
          chk(last_waddr == v.rg, "R4", "write register", last_waddr, v.rg);
          chk(last_wdata == v.dat, "R7", "write data", last_wdata, v.dat);
          chk(oe_cnt == oe0, "R7", "drive during write", oe_cnt - oe0, 0);
          exp_mem[v.rg] = v.dat;
        end
        2'd2: begin
          chk(t1 == 1'b0, "R5", "first turnaround enable", t1, 0);
          chk(t2 == 1'b1 && t2l == 1'b0, "R5", "second turnaround", {t2, t2l}, 2'b10);
          chk(rd == exp_mem[v.rg], "R6", "read data", rd, exp_mem[v.rg]);
          chk(rd_cnt - rd0 == 1, "R6", "read strobes", rd_cnt - rd0, 1);
          chk(eo == 1'b0, "R8", "released after data", eo, 0);
          chk(we_cnt == we0, "R7", "no write during read", we_cnt - we0, 0);
        end
        default: begin
          chk(we_cnt == we0 && rd_cnt == rd0, (v.op[1] ^ v.op[0]) ? "R1" : "R3",
              "strobes on ignored frame", (we_cnt - we0) + (rd_cnt - rd0), 0);
          chk(oe_cnt == oe0, (v.op[1] ^ v.op[0]) ? "R1" : "R3",
              "drive on ignored frame", oe_cnt - oe0, 0);
          if (v.op == 2'b10) chk(rd == 16'hFFFF, "R1", "foreign read line", rd, 16'hFFFF);
        end
      endcase
    end

    // reset in the middle of a read
    v = vec_t'(VT[1]);
    send_head(v);
    mbit(1'b1, ln, oe);
    mbit(1'b1, ln, oe);
    for (int i = 0; i < 4; i++) mbit(1'b1, ln, oe);
    chk(mdio_oe == 1'b1, "R8", "driving mid read", mdio_oe, 1);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(mdio_oe == 1'b0, "R9", "drive stopped by reset", mdio_oe, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) mbit(1'b1, ln, oe);
    do_frame(vec_t'(VT[12]), rd, t1, t2, t2l, eo);
    chk(rd == exp_mem[3], "R9", "read after reset", rd, exp_mem[3]);

    chk(late == 0, "R10", "output changes away from edge", late, 0);
    summary();
  end

endmodule